// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Encoder

This block watches a vector of interrupt requests that are already pending and enabled, up to 64 lines wide. For each of two interrupt classes, normal and fast, it picks one winning request. It reports that winner as a byte offset into a table of handler entries. The requests are split between the classes by a per-line select input. Both classes then go through the same arbitration rules.

The eight lowest request lines each carry a 3-bit priority value held in a software-writable register. All lines from eight upward rank below any of those eight, in fixed index order. Each class's result is registered once per clock. The result is the winner's index plus one, scaled by four, and zero means nothing of that class is pending.

Software reaches the priority register and both status words through a small word-addressed read/write port. Reads have no side effects.

Top module: `prio_vec_encoder`

## Requirements
- R1: After reset the priority register reads 0x00FAC688. The 3-bit field for line n sits at bits [3n+2:3n] and resets to the value n. The register is read at address 0.
- R2: A write to address 0 replaces all eight fields on the next clock edge. Bits 31:24 of the written word are ignored and always read back as zero.
- R3: A status word equals (winning index + 1) × 4. Bits 1:0 and all bits above bit 8 are zero. Line 63 therefore gives 256. The normal-class word reads at address 1 and the fast-class word at address 2, and both also appear on dedicated output ports.
- R4: A status word is zero when no request of its class was pending at the previous clock edge.
- R5: Among lines 0–7, the line with the numerically larger programmed value wins. When two values are equal, the lower index wins.
- R6: Any pending line among 0–7 beats every line from 8 upward. Among lines 8 and above, the lower index wins.
- R7: Line n belongs to the fast class when its select bit is 1 and to the normal class when it is 0. Each class considers only its own lines, and both classes use the same priority fields.
- R8: Each status word reflects the requests and priorities sampled at the previous clock edge. Reading any address leaves both status words unchanged.
- R9: If a priority write and a request change fall in the same cycle, the status that follows that edge still uses the old priorities. The new priorities apply from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 64 | Pending, enabled interrupt requests |
| fast_sel_i | input | 64 | Per-line class select, 1 = fast class |
| reg_addr_i | input | 2 | Register word address (0 priority, 1 normal status, 2 fast status) |
| reg_wr_i | input | 1 | Write strobe, acts only at address 0 |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word |
| norm_word_o | output | 32 | Registered normal-class status word |
| fast_word_o | output | 32 | Registered fast-class status word |

## Verification
A priority write and a change of the request pattern can land in the same clock cycle. The status produced at that edge must still rank the requests by the old fields, and the status one edge later must rank them by the new fields. The bench provokes this by writing a field that reverses the order of two pending lines in the same cycle that those lines are raised. The scoreboard queues two expected words computed from its own shadow of the register, one before and one after the shadow update, and compares them on consecutive cycles.

// File: rtl/pve_pkg.sv
package pve_pkg;

  localparam int WORD_W = 32;

  // Reset image of the priority fields: field n holds n (modulo the field range)
  function automatic logic [WORD_W-1:0] default_prio(input int slots, input int fw);
    logic [WORD_W-1:0] v;
    v = '0;
    for (int n = 0; n < slots; n++) begin
      v = v | (WORD_W'(n % (1 << fw)) << (n * fw));
    end
    return v;
  endfunction

  // Status word: (index + 1) scaled by four, zero when nothing won
  function automatic logic [WORD_W-1:0] make_word(input logic hit, input logic [15:0] idx);
    logic [WORD_W-1:0] code;
    code = WORD_W'(idx) + WORD_W'(1);
    return hit ? (code << 2) : '0;
  endfunction

endpackage

// File: rtl/pve_prio_regs.sv
module pve_prio_regs #(
  parameter int SLOTS  = 8,
  parameter int PRIO_W = 3,
  localparam int FIELDS_W = SLOTS * PRIO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic [FIELDS_W-1:0] wdata_i,
  output logic [FIELDS_W-1:0] fields_o
);
  import pve_pkg::*;

  localparam logic [WORD_W-1:0] RST_IMAGE = default_prio(SLOTS, PRIO_W);

  logic [FIELDS_W-1:0] fields_q;

  // One register slice per slot, so each field keeps its own reset value
  for (genvar n = 0; n < SLOTS; n++) begin : g_field
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        fields_q[n*PRIO_W +: PRIO_W] <= RST_IMAGE[n*PRIO_W +: PRIO_W];
      else if (wr_i)
        fields_q[n*PRIO_W +: PRIO_W] <= wdata_i[n*PRIO_W +: PRIO_W];
    end
  end

  assign fields_o = fields_q;

  // R2
  prio_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> fields_q == $past(wdata_i));

  // R2
  prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(fields_q));

endmodule

// File: rtl/pve_prog_pick.sv
module pve_prog_pick #(
  parameter int NUM_LINES = 64,
  parameter int SLOTS     = 8,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [SLOTS-1:0]        req_i,
  input  logic [SLOTS*PRIO_W-1:0] prio_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRIO_W-1:0]       val_o
);
  // Larger value wins; strict compare keeps the lower index on a tie
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    val_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (req_i[i] && (!hit_o || (prio_i[i*PRIO_W +: PRIO_W] > val_o))) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        val_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/pve_fixed_pick.sv
module pve_fixed_pick #(
  parameter int NUM_LINES = 64,
  parameter int SLOTS     = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [SLOTS-1:0] unused_low_lines;
  assign unused_low_lines = req_i[SLOTS-1:0];

  // Scan from the top down so the last match is the lowest index
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= SLOTS; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pve_class_arbiter.sv
module pve_class_arbiter #(
  parameter int NUM_LINES = 64,
  parameter int SLOTS     = 8,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int CODE_W   = $clog2(NUM_LINES + 1),
  localparam int WORD_W   = pve_pkg::WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_LINES-1:0]    req_i,
  input  logic [SLOTS*PRIO_W-1:0] prio_i,
  output logic [WORD_W-1:0]       word_o
);
  import pve_pkg::*;

  logic              low_hit, high_hit, win_hit;
  logic [IDX_W-1:0]  low_idx, high_idx, win_idx;
  logic [PRIO_W-1:0] low_val;
  logic [WORD_W-1:0] word_q;

  pve_prog_pick #(.NUM_LINES(NUM_LINES), .SLOTS(SLOTS), .PRIO_W(PRIO_W)) u_prog (
    .req_i (req_i[SLOTS-1:0]),
    .prio_i(prio_i),
    .hit_o (low_hit),
    .idx_o (low_idx),
    .val_o (low_val)
  );

  pve_fixed_pick #(.NUM_LINES(NUM_LINES), .SLOTS(SLOTS)) u_fixed (
    .req_i(req_i),
    .hit_o(high_hit),
    .idx_o(high_idx)
  );

  // Programmable segment always outranks the fixed segment
  assign win_hit = low_hit | high_hit;
  assign win_idx = low_hit ? low_idx : high_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= make_word(win_hit, 16'(win_idx));
  end

  assign word_o = word_q;

  // R5
  win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> req_i[win_idx]);

  // R6
  low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && (win_idx >= IDX_W'(SLOTS))) |-> (req_i[SLOTS-1:0] == '0));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |=> (word_q == '0));

  // R8
  busy_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |=> (word_q != '0));

  // R3
  word_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q[1:0] == 2'b00) && (word_q[WORD_W-1:CODE_W+2] == '0));

  // R5
  low_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_hit |-> (low_val == prio_i[low_idx*PRIO_W +: PRIO_W]));

endmodule

// File: rtl/prio_vec_encoder.sv
module prio_vec_encoder #(
  parameter int NUM_LINES = 64,
  parameter int SLOTS     = 8,
  parameter int PRIO_W    = 3,
  localparam int WORD_W   = pve_pkg::WORD_W,
  localparam int FIELDS_W = SLOTS * PRIO_W,
  localparam int NCLASS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] fast_sel_i,
  input  logic [1:0]           reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  output logic [WORD_W-1:0]    norm_word_o,
  output logic [WORD_W-1:0]    fast_word_o
);
  localparam logic [1:0] ADDR_PRIO = 2'd0;
  localparam logic [1:0] ADDR_NORM = 2'd1;
  localparam logic [1:0] ADDR_FAST = 2'd2;

  logic                 prio_wr;
  logic [FIELDS_W-1:0]  prio_fields;
  logic [NUM_LINES-1:0] cls_req  [NCLASS];
  logic [WORD_W-1:0]    cls_word [NCLASS];
  logic                 unused_rsvd_bits;

  assign prio_wr          = reg_wr_i && (reg_addr_i == ADDR_PRIO);
  assign unused_rsvd_bits = ^reg_wdata_i[WORD_W-1:FIELDS_W];

  pve_prio_regs #(.SLOTS(SLOTS), .PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (prio_wr),
    .wdata_i (reg_wdata_i[FIELDS_W-1:0]),
    .fields_o(prio_fields)
  );

  // Class 0 = normal, class 1 = fast; both share one priority image
  assign cls_req[0] = req_i & ~fast_sel_i;
  assign cls_req[1] = req_i &  fast_sel_i;

  for (genvar c = 0; c < NCLASS; c++) begin : g_class
    pve_class_arbiter #(.NUM_LINES(NUM_LINES), .SLOTS(SLOTS), .PRIO_W(PRIO_W)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (cls_req[c]),
      .prio_i(prio_fields),
      .word_o(cls_word[c])
    );
  end

  assign norm_word_o = cls_word[0];
  assign fast_word_o = cls_word[1];

  always_comb begin
    case (reg_addr_i)
      ADDR_PRIO: reg_rdata_o = WORD_W'(prio_fields);
      ADDR_NORM: reg_rdata_o = cls_word[0];
      ADDR_FAST: reg_rdata_o = cls_word[1];
      default:   reg_rdata_o = '0;
    endcase
  end

  // R7
  class_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_word_o != '0) |-> (norm_word_o != fast_word_o));

  // R8
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(req_i) && $stable(fast_sel_i) && !reg_wr_i && !$past(reg_wr_i))
      |=> $stable(norm_word_o) && $stable(fast_word_o));

  // R2
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_PRIO) |-> (reg_rdata_o[WORD_W-1:FIELDS_W] == '0));

endmodule

// File: tb/prio_vec_encoder_bench.sv
module prio_vec_encoder_bench;

  typedef struct {
    longint      due;
    logic [31:0] norm;
    logic [31:0] fast;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic [63:0] sel = '0;
  logic [1:0]  addr = 2'd0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, norm_w, fast_w;

  int     total = 0;
  int     bad = 0;
  longint cyc = 0;
  exp_t   sb[$];
  logic [23:0] shadow = 24'hFAC688;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  prio_vec_encoder u_prio_vec_encoder (
    .clk(clk), .rst_n(rst_n), .req_i(req), .fast_sel_i(sel),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .norm_word_o(norm_w), .fast_word_o(fast_w)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Score-based reference: highest score wins
  function automatic logic [31:0] ref_word(input logic [63:0] r, input logic [63:0] s,
                                           input bit fast, input logic [23:0] p);
    int best = -1;
    int top = 0;
    for (int i = 0; i < 64; i++) begin
      if (r[i] && (s[i] == fast)) begin
        int score;
        score = (i < 8) ? (1000 + 100 * int'(p[3*i +: 3]) - i) : (500 - i);
        if (score > top) begin top = score; best = i; end
      end
    end
    return (best < 0) ? 32'd0 : 32'((best + 1) * 4);
  endfunction

  // Driver: called at a falling edge; applies one cycle of stimulus
  task automatic step(input logic [63:0] r, input logic [63:0] s,
                      input bit do_wr, input logic [31:0] d, input string tag);
    exp_t e;
    req = r; sel = s; wr = do_wr; wdata = d; addr = 2'd0;
    e.due  = cyc + 1;
    e.norm = ref_word(r, s, 1'b0, shadow);
    e.fast = ref_word(r, s, 1'b1, shadow);
    e.tag  = tag;
    sb.push_back(e);
    if (do_wr) shadow = d[23:0];
    @(negedge clk);
    wr = 1'b0;
  endtask

  // Monitor: compares queued expectations at the falling edge they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " norm"}, norm_w, e.norm);
      check({e.tag, " fast"}, fast_w, e.fast);
    end
  end

  task automatic read_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_chk(2'd0, 32'h00FAC688, "R1 reset priority image");
    check("R4 reset normal word", norm_w, 32'd0);
    check("R4 reset fast word", fast_w, 32'd0);

    step(64'h1, '0, 0, 0, "R3 line0 -> 4");
    step(64'h28, '0, 0, 0, "R5 default lines 3,5");
    step(64'h0000_0100_0000_0400, '0, 0, 0, "R6 lines 10,40");
    step(64'h8000_0000_0000_0000, '0, 0, 0, "R3 line63 -> 256");
    step(64'h201, '0, 0, 0, "R6 line0 over line9");
    step(64'h84, 64'h80, 0, 0, "R7 class split");
    step(64'h0, '0, 0, 0, "R4 idle");
    step(64'hFFFF_FFFF_FFFF_FF00, 64'hAAAA_AAAA_AAAA_AA00, 0, 0, "R7 high lines both classes");

    // Reserved bits written as ones, fields all zero
    step(64'h0, '0, 1, 32'hFF00_0000, "R2 write with reserved ones");
    read_chk(2'd0, 32'h0, "R2 reserved bits read zero");
    step(64'h50, '0, 0, 0, "R5 tie lines 4,6");
    step(64'h50, 64'h50, 0, 0, "R7 tie in fast class");

    // Line 6 at 5, then same-cycle write raising line 1 to 7 with requests
    step(64'h0, '0, 1, 32'h0014_0000, "R2 program line6");
    step(64'h42, '0, 1, 32'h0014_0038, "R9 old priorities at write edge");
    step(64'h42, '0, 0, 0, "R9 new priorities next edge");
    read_chk(2'd0, 32'h0014_0038, "R2 readback");

    // Reads with held requests must not disturb status
    step(64'h42, 64'h40, 0, 0, "R8 hold setup");
    for (int k = 0; k < 3; k++) begin
      read_chk(2'd1, 32'd8, "R8 normal read");
      read_chk(2'd2, 32'd28, "R8 fast read");
      check("R8 normal port stable", norm_w, 32'd8);
      @(negedge clk);
    end
    read_chk(2'd3, 32'd0, "R3 unused address");

    for (int k = 0; k < 300; k++) begin
      logic [63:0] r, s;
      r = {$urandom, $urandom};
      if (k % 3 == 0) r = r & 64'h0000_0000_0000_00FF;
      if (k % 5 == 0) r = r & 64'hFFFF_FFFF_FFFF_FF00;
      s = {$urandom, $urandom};
      step(r, s, (k % 7 == 0), $urandom, "R5 R6 R7 mixed");
    end

    step(64'h0, '0, 0, 0, "R4 final idle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule